// File: doc/BRIEF.md
# Wake-Up Tone Period Window Validator

This block qualifies a digital wake-up tone by timing it. The controller clock runs well above the tone frequency. On each sampled rising edge of the tone, the block measures how many controller clocks have passed since the previous edge. It then checks that count against a programmable inclusive window. The lower count bound rejects tones that are too fast, and the upper bound rejects tones that are too slow. The window acts as a digital hysteresis band on the accepted modulation frequency and takes the place of an analog band-pass stage.

The block keeps a run of consecutive in-window periods. Once the run reaches the programmed length, it raises a detect flag. A period that falls outside the window clears the run and raises an invalid flag for that verdict. Example: with a 140 kHz controller clock, a 14 kHz tone gives 10 clocks per period, and bounds of 8 and 12 accept roughly 11.7 to 17.5 kHz. The upstream sequencer holds the enable high while it wants a verdict and drops it to discard all progress.

Top module: `fwin_validator`

## Requirements
- R1: After reset, both `tone_ok` and `bad_period` are low.
- R2: When `en` is low at a clock edge, both outputs are low in the following cycle and all timing and run progress is discarded. Edge pulses seen while `en` is low change neither output.
- R3: The first `edge_pulse` sampled with `en` high after enable, reset or a discard only starts timing. In the following cycle neither output is raised.
- R4: The period P of a later sampled edge is the number of clock cycles since the previous sampled edge (edges in cycles t and t+P). It is in-window when `lim_min` <= P <= `lim_max`, both bounds inclusive.
- R5: An out-of-window period sets `bad_period` high in the cycle after that edge, drops `tone_ok` and restarts the run at zero.
- R6: `tone_ok` goes high in the cycle after the edge that completes `need_cycles` consecutive in-window periods. It then stays high while `en` is high until an out-of-window period occurs. A `need_cycles` value of 0 behaves as 1.
- R7: A run of in-window periods shorter than `need_cycles` never raises `tone_ok`.
- R8: The period timer stops at `lim_max`+1, so an arbitrarily long gap between edges is judged too slow and never wraps into the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Measurement enable from the sequencer; low discards progress |
| edge_pulse | input | 1 | One-cycle pulse per tone rising edge |
| lim_min | input | CNT_W | Smallest accepted period in clocks |
| lim_max | input | CNT_W | Largest accepted period in clocks; must be below 2^CNT_W-1 |
| need_cycles | input | NCYC_W | Consecutive in-window periods required for detect |
| tone_ok | output | 1 | Tone accepted |
| bad_period | output | 1 | Out-of-window period seen on the previous edge |

## Verification
Both outputs are registered once behind the edge that is judged, so every verdict is due exactly one clock after the edge is sampled. The bench drives each edge at a falling clock edge and reads both outputs at the next falling edge, which is the first point where that verdict is visible. A discard through `en` is likewise read one falling edge after `en` drops. The bench sweeps periods from 2 to 16 clocks around an 8..12 window, every run length from 0 to 7, and a 140-clock gap that would land inside the window if the timer wrapped.

// File: rtl/fwin_pkg.sv
package fwin_pkg;
   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_IN   = 2'd1,
      VERD_OUT  = 2'd2
   } verdict_t;
endpackage

// File: rtl/fwin_period_ctr.sv
module fwin_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] lim_max,
   output logic             armed_o,
   output logic [CNT_W:0]   period_o,
   output logic             meas_o
);
   logic           armed_q;
   logic [CNT_W:0] cnt_q;
   logic [CNT_W:0] ceiling;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("fwin_period_ctr: CNT_W must be at least 2");
      end
   endgenerate

   assign ceiling = {1'b0, lim_max} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (edge_i) begin
         armed_q <= 1'b1;
         cnt_q   <= {{CNT_W{1'b0}}, 1'b1};
      end else if (armed_q && (cnt_q < ceiling)) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign armed_o  = armed_q;
   assign period_o = cnt_q;
   assign meas_o   = en && edge_i && armed_q;

   // R8: between edges the timer never moves backwards (no wrap)
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && armed_q && !edge_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/fwin_window_cmp.sv
module fwin_window_cmp
   import fwin_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W:0]   period_i,
   input  logic [CNT_W-1:0] lim_min,
   input  logic [CNT_W-1:0] lim_max,
   input  logic             meas_i,
   output verdict_t         verdict_o
);
   logic above_min;
   logic below_max;

   assign above_min = period_i >= {1'b0, lim_min};
   assign below_max = period_i <= {1'b0, lim_max};

   always_comb begin
      if (!meas_i)                       verdict_o = VERD_NONE;
      else if (above_min && below_max)   verdict_o = VERD_IN;
      else                               verdict_o = VERD_OUT;
   end
endmodule

// File: rtl/fwin_run_ctr.sv
module fwin_run_ctr
   import fwin_pkg::*;
#(
   parameter int NCYC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  verdict_t          verdict_i,
   input  logic [NCYC_W-1:0] need,
   output logic              ok_o,
   output logic              bad_o
);
   logic [NCYC_W:0] run_q;
   logic [NCYC_W:0] need_eff;
   logic [NCYC_W:0] run_inc;
   logic            ok_q;
   logic            bad_q;

   generate
      if (NCYC_W < 1) begin : g_bad_width
         $error("fwin_run_ctr: NCYC_W must be at least 1");
      end
   endgenerate

   assign need_eff = (need == '0) ? {{NCYC_W{1'b0}}, 1'b1} : {1'b0, need};
   assign run_inc  = run_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         run_q <= '0;
         ok_q  <= 1'b0;
         bad_q <= 1'b0;
      end else begin
         case (verdict_i)
            VERD_IN: begin
               if (run_q < need_eff) run_q <= run_inc;
               ok_q  <= (run_inc >= need_eff);
               bad_q <= 1'b0;
            end
            VERD_OUT: begin
               run_q <= '0;
               ok_q  <= 1'b0;
               bad_q <= 1'b1;
            end
            default: bad_q <= 1'b0;
         endcase
      end
   end

   assign ok_o  = ok_q;
   assign bad_o = bad_q;

   // R2: a low enable clears both flags on the next cycle
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!ok_q && !bad_q));
   // R5: an invalid period never coexists with an accepted tone
   a_r5_bad_drops_ok: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |-> !ok_q);
   // R6: acceptance only follows an in-window verdict
   a_r6_ok_from_in: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_q) |-> $past(verdict_i == VERD_IN));
endmodule

// File: rtl/fwin_validator.sv
module fwin_validator
   import fwin_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int NCYC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              edge_pulse,
   input  logic [CNT_W-1:0]  lim_min,
   input  logic [CNT_W-1:0]  lim_max,
   input  logic [NCYC_W-1:0] need_cycles,
   output logic              tone_ok,
   output logic              bad_period
);
   logic           armed;
   logic [CNT_W:0] period;
   logic           meas;
   verdict_t       verdict;

   fwin_period_ctr #(.CNT_W(CNT_W)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .edge_i   (edge_pulse),
      .lim_max  (lim_max),
      .armed_o  (armed),
      .period_o (period),
      .meas_o   (meas)
   );

   fwin_window_cmp #(.CNT_W(CNT_W)) u_window (
      .period_i  (period),
      .lim_min   (lim_min),
      .lim_max   (lim_max),
      .meas_i    (meas),
      .verdict_o (verdict)
   );

   fwin_run_ctr #(.NCYC_W(NCYC_W)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .verdict_i (verdict),
      .need      (need_cycles),
      .ok_o      (tone_ok),
      .bad_o     (bad_period)
   );

   // R3: the arming edge yields no verdict
   a_r3_first_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_pulse && !armed) |=> (!tone_ok && !bad_period));
   // R5: an invalid flag always traces back to a sampled edge
   a_r5_bad_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_period) |-> $past(en && edge_pulse));
endmodule

// File: tb/test_fwin_validator.sv
module test_fwin_validator;
   localparam int CW = 6;
   localparam int NW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          edge_pulse = 1'b0;
   logic [CW-1:0] lim_min = 6'd8;
   logic [CW-1:0] lim_max = 6'd12;
   logic [NW-1:0] need_cycles = 3'd5;
   logic          tone_ok;
   logic          bad_period;

   int checks = 0;
   int errors = 0;
   int m_run  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   fwin_validator #(.CNT_W(CW), .NCYC_W(NW)) i_fwin_validator (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .edge_pulse  (edge_pulse),
      .lim_min     (lim_min),
      .lim_max     (lim_max),
      .need_cycles (need_cycles),
      .tone_ok     (tone_ok),
      .bad_period  (bad_period)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 200000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < 200000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // arming edge: pulse now, check next falling edge (R3)
   task automatic first_edge();
      edge_pulse = 1'b1;
      @(negedge clk);
      edge_pulse = 1'b0;
      m_run = 0;
      chk("R3 ok after arming edge", tone_ok, 1'b0);
      chk("R3 bad after arming edge", bad_period, 1'b0);
   endtask

   // next edge P clocks after the previous one; verdict due one clock later
   task automatic period(input int p, input string req);
      int  need_eff;
      logic inwin;
      repeat (p - 1) @(negedge clk);
      edge_pulse = 1'b1;
      @(negedge clk);
      edge_pulse = 1'b0;
      need_eff = (need_cycles == 0) ? 1 : int'(need_cycles);
      inwin = (p >= int'(lim_min)) && (p <= int'(lim_max));
      if (inwin) m_run = m_run + 1; else m_run = 0;
      chk({req, " tone_ok"}, tone_ok, inwin && (m_run >= need_eff));
      chk({req, " bad_period"}, bad_period, !inwin);
   endtask

   task automatic disable_and_check(input string req);
      en = 1'b0;
      @(negedge clk);
      chk({req, " ok cleared"}, tone_ok, 1'b0);
      chk({req, " bad cleared"}, bad_period, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 tone_ok reset", tone_ok, 1'b0);
      chk("R1 bad_period reset", bad_period, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: edges while disabled are ignored
      for (int i = 0; i < 4; i++) begin
         edge_pulse = 1'b1;
         @(negedge clk);
         edge_pulse = 1'b0;
         repeat (2) @(negedge clk);
         chk("R2 ok idle while disabled", tone_ok, 1'b0);
         chk("R2 bad idle while disabled", bad_period, 1'b0);
      end

      // R4/R5/R6/R7: sweep period lengths around window 8..12, need 5
      for (int p = 2; p <= 16; p++) begin
         en = 1'b1;
         first_edge();
         for (int k = 0; k < 6; k++) period(p, "R4 sweep");
         disable_and_check("R2 after sweep");
      end

      // R6: every run length with in-window period 10 (need 0 acts as 1)
      for (int n = 0; n < 8; n++) begin
         need_cycles = NW'(n);
         en = 1'b1;
         first_edge();
         for (int k = 0; k < 9; k++) period(10, "R6 run length");
         disable_and_check("R2 after run length");
      end

      // R7: valid frequency but one cycle short
      need_cycles = 3'd5;
      en = 1'b1;
      first_edge();
      for (int k = 0; k < 4; k++) period(9, "R7 short burst");
      disable_and_check("R2 after short burst");

      // R5: invalid period in mid-run restarts the count
      en = 1'b1;
      first_edge();
      for (int k = 0; k < 3; k++) period(11, "R5 pre-fault");
      period(15, "R5 fault");
      for (int k = 0; k < 6; k++) period(8, "R5 recount");
      period(5, "R5 drop after accept");
      period(12, "R5 after drop");

      // R8: a 140-clock gap would wrap into the window without saturation
      period(140, "R8 long gap");
      for (int k = 0; k < 5; k++) period(10, "R8 recovery");

      // R2: discard mid-run, then R3 re-arm on the next edge
      disable_and_check("R2 mid-run discard");
      en = 1'b1;
      first_edge();
      for (int k = 0; k < 5; k++) period(12, "R3 rearm count");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule